// File: doc/BRIEF.md
# Interrupt Request Front-End

This block sits between two asynchronous interrupt pins and a processor core. It brings the maskable request line and the non-maskable line into the core clock domain through a chain of synchronizer flops. On the non-maskable line it accepts a rising edge only if the synchronized line was low for a minimum number of consecutive clocks just before that edge. An accepted edge sets a pending flag, which stays set until the core acknowledges it.

The maskable line is a level request. It is gated by the core's interrupt-enable flag and held back while a non-maskable request is pending. Once such a request is taken, a state machine asks the bus unit for two interrupt-acknowledge cycles and holds the bus lock across both. It captures the vector byte when the second cycle completes and then presents that byte for one clock. If the request line falls before the bus unit completes either cycle, the sequence is abandoned and no vector is delivered.

The sequencer has four states. SEQ_IDLE goes to SEQ_ACK1 when the gated request is high. SEQ_ACK1 goes to SEQ_ACK2 on cycle completion while the request is still high, and back to SEQ_IDLE on completion once the request has fallen. SEQ_ACK2 goes to SEQ_DELIVER on completion with the request high (capturing the vector), and back to SEQ_IDLE on completion with the request low. SEQ_DELIVER always returns to SEQ_IDLE after one clock.

Top module: `irq_front_end`

## Requirements
- R1: Each pin passes through SYNC_STAGES (default 2) flops. A change on intr_pin reaches intr_req exactly two clock edges later when irq_enable is high and no NMI is pending.
- R2: nmi_pending is set only by a synchronized low-to-high transition that was preceded by at least MIN_LOW (default 4) consecutive synchronized low samples. Shorter low runs set nothing.
- R3: The low-run count saturates at MIN_LOW, so a low run of any greater length still qualifies the next rising edge.
- R4: nmi_pending stays set until a clock with nmi_ack high clears it. If a qualifying edge and nmi_ack occur in the same clock, the flag stays set. nmi_ack with no pending request has no effect.
- R5: intr_req is high exactly when the synchronized request line is high, irq_enable is high and nmi_pending is low.
- R6: The clock after intr_req is high in SEQ_IDLE, ack_req rises with ack_second low (first cycle). After the first bus_done with the request still high, ack_req stays high and ack_second is 1 (second cycle).
- R7: bus_lock is high for every clock of both acknowledge cycles, without a gap between them, and is low in every other clock.
- R8: On bus_done in the second cycle, ack_data is stored. The next clock vec_valid is high for exactly one clock, and vec_out holds the byte until the next capture. vec_out resets to 0.
- R9: If the synchronized request line is low when bus_done completes either cycle, the sequence returns to SEQ_IDLE and does not assert vec_valid.
- R10: While nmi_pending is high, no acknowledge sequence starts.
- R11: During and after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intr_pin | input | 1 | Asynchronous maskable request, active high, level |
| nmi_pin | input | 1 | Asynchronous non-maskable request, rising edge |
| irq_enable | input | 1 | Core interrupt-enable flag |
| nmi_ack | input | 1 | Core takes the pending non-maskable request |
| bus_done | input | 1 | Bus unit completes the current acknowledge cycle |
| ack_data | input | VEC_W | Low data byte returned by the acknowledge cycle |
| nmi_pending | output | 1 | Non-maskable request waiting for the core |
| intr_req | output | 1 | Gated maskable request to the core |
| ack_req | output | 1 | Acknowledge cycle requested from the bus unit |
| ack_second | output | 1 | 0 for the first acknowledge cycle, 1 for the second |
| bus_lock | output | 1 | Bus locked across the acknowledge pair |
| vec_valid | output | 1 | One-clock strobe that the vector is available |
| vec_out | output | VEC_W | Captured interrupt vector |

## Verification
The bench sends non-maskable low runs of two, three, four and many clocks. A qualifier that counts off by one, or whose counter wraps, would accept the short runs or miss the long one. It raises acknowledge and a new edge in the same clock, where a design that gives clear priority would lose the second request. It drops the maskable line inside each acknowledge cycle, where a sequencer that ignores the drop would deliver a stale vector or hold the lock. It also holds a maskable request behind a pending non-maskable one, where a design without priority would start bus cycles. A synchronizer of the wrong depth shows up as intr_req moving in the wrong clock.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ACK1    = 2'd1,
        SEQ_ACK2    = 2'd2,
        SEQ_DELIVER = 2'd3
    } seq_state_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/nmi_qualifier.sv
module nmi_qualifier #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_s,
    input  logic nmi_ack,
    output logic nmi_pending
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] SAT = CW'(MIN_LOW);

    logic [CW-1:0] low_run;
    logic          qualified;

    assign qualified = nmi_s && (low_run == SAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (nmi_s) begin
            low_run <= '0;
        end else if (low_run != SAT) begin
            low_run <= low_run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_pending <= 1'b0;
        end else if (qualified) begin
            nmi_pending <= 1'b1;
        end else if (nmi_ack) begin
            nmi_pending <= 1'b0;
        end
    end

    assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= SAT);

    assert_edge_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pending) |-> ($past(nmi_s, 1) && !$past(nmi_s, 2)));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pending && nmi_ack && !nmi_s) |=> !nmi_pending);
endmodule

// File: rtl/inta_seq.sv
module inta_seq
    import irq_fe_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             intr_s,
    input  logic             bus_done,
    input  logic [VEC_W-1:0] ack_data,
    output logic             ack_req,
    output logic             ack_second,
    output logic             bus_lock,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);
    seq_state_t state, state_nx;
    logic       capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        unique case (state)
            SEQ_IDLE: if (start_req) state_nx = SEQ_ACK1;
            SEQ_ACK1: if (bus_done)  state_nx = intr_s ? SEQ_ACK2 : SEQ_IDLE;
            SEQ_ACK2: if (bus_done) begin
                if (intr_s) begin
                    state_nx = SEQ_DELIVER;
                    capture  = 1'b1;
                end else begin
                    state_nx = SEQ_IDLE;
                end
            end
            SEQ_DELIVER: state_nx = SEQ_IDLE;
            default:     state_nx = SEQ_IDLE;
        endcase
    end

    always_comb begin
        ack_req    = 1'b0;
        ack_second = 1'b0;
        bus_lock   = 1'b0;
        vec_valid  = 1'b0;
        unique case (state)
            SEQ_IDLE: ;
            SEQ_ACK1: begin
                ack_req  = 1'b1;
                bus_lock = 1'b1;
            end
            SEQ_ACK2: begin
                ack_req    = 1'b1;
                ack_second = 1'b1;
                bus_lock   = 1'b1;
            end
            SEQ_DELIVER: vec_valid = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       vec_out <= '0;
        else if (capture) vec_out <= ack_data;
    end

    assert_lock_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_second) |-> $past(bus_lock));

    assert_second_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_second) |-> ($past(bus_done) && $past(intr_s)));

    assert_vec_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    assert_vec_after_ack2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> ($past(ack_second) && $past(intr_s)));

    assert_lock_off_on_deliver_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !bus_lock);
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 4,
    parameter int VEC_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             intr_pin,
    input  logic             nmi_pin,
    input  logic             irq_enable,
    input  logic             nmi_ack,
    input  logic             bus_done,
    input  logic [VEC_W-1:0] ack_data,
    output logic             nmi_pending,
    output logic             intr_req,
    output logic             ack_req,
    output logic             ack_second,
    output logic             bus_lock,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);
    localparam int PINS = 2;

    logic [PINS-1:0] pins_s;
    logic            intr_s;
    logic            nmi_s;

    irq_sync #(.STAGES(SYNC_STAGES), .W(PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({nmi_pin, intr_pin}),
        .dout (pins_s)
    );

    assign intr_s = pins_s[0];
    assign nmi_s  = pins_s[1];

    nmi_qualifier #(.MIN_LOW(MIN_LOW)) u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_s      (nmi_s),
        .nmi_ack    (nmi_ack),
        .nmi_pending(nmi_pending)
    );

    assign intr_req = intr_s && irq_enable && !nmi_pending;

    inta_seq #(.VEC_W(VEC_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (intr_req),
        .intr_s    (intr_s),
        .bus_done  (bus_done),
        .ack_data  (ack_data),
        .ack_req   (ack_req),
        .ack_second(ack_second),
        .bus_lock  (bus_lock),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    assert_nmi_blocks_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> !$past(nmi_pending));
endmodule

// File: tb/sim_irq_front_end.sv
`timescale 1ns/1ps
module sim_irq_front_end;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       intr_pin = 1'b0, nmi_pin = 1'b0, irq_enable = 1'b0;
    logic       nmi_ack = 1'b0, bus_done = 1'b0;
    logic [7:0] ack_data = 8'h00;
    logic       nmi_pending, intr_req, ack_req, ack_second, bus_lock, vec_valid;
    logic [7:0] vec_out;

    int    checks = 0;
    int    fails  = 0;
    bit    finished = 1'b0;
    string phase = "R11 reset";

    always #2 clk = ~clk;

    irq_front_end u0 (
        .clk(clk), .rst_n(rst_n), .intr_pin(intr_pin), .nmi_pin(nmi_pin),
        .irq_enable(irq_enable), .nmi_ack(nmi_ack), .bus_done(bus_done),
        .ack_data(ack_data), .nmi_pending(nmi_pending), .intr_req(intr_req),
        .ack_req(ack_req), .ack_second(ack_second), .bus_lock(bus_lock),
        .vec_valid(vec_valid), .vec_out(vec_out)
    );

    // behavioural reference: pin history queues and integer counters
    bit   q_intr[$];
    bit   q_nmi[$];
    int   m_low, m_st;
    bit   m_pend;
    int   m_vec;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_intr = '{0, 0};
            q_nmi  = '{0, 0};
            m_low = 0; m_st = 0; m_pend = 0; m_vec = 0;
        end else begin
            bit n_s, i_s, qual, go;
            n_s  = q_nmi[0];
            i_s  = q_intr[0];
            qual = n_s && (m_low >= 4);
            go   = i_s && irq_enable && !m_pend;
            if (qual) m_pend = 1;
            else if (nmi_ack) m_pend = 0;
            m_low = n_s ? 0 : (m_low < 4 ? m_low + 1 : 4);
            case (m_st)
                0: if (go) m_st = 1;
                1: if (bus_done) m_st = i_s ? 2 : 0;
                2: if (bus_done) begin
                    if (i_s) begin m_vec = ack_data; m_st = 3; end
                    else m_st = 0;
                end
                default: m_st = 0;
            endcase
            void'(q_intr.pop_front()); q_intr.push_back(intr_pin);
            void'(q_nmi.pop_front());  q_nmi.push_back(nmi_pin);
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("nmi_pending", int'(nmi_pending), int'(m_pend));
        chk("intr_req", int'(intr_req), int'(q_intr[0] && irq_enable && !m_pend));
        chk("ack_req", int'(ack_req), int'(m_st == 1 || m_st == 2));
        chk("ack_second", int'(ack_second), int'(m_st == 2));
        chk("bus_lock", int'(bus_lock), int'(m_st == 1 || m_st == 2));
        chk("vec_valid", int'(vec_valid), int'(m_st == 3));
        chk("vec_out", int'(vec_out), m_vec);
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic done_pulse(input logic [7:0] d);
        ack_data = d; bus_done = 1'b1;
        steps(1);
        bus_done = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        phase = "R11 reset";
        steps(3);
        rst_n = 1'b1;
        steps(2);

        phase = "R1 sync latency";
        irq_enable = 1'b1; intr_pin = 1'b1;
        steps(3);
        phase = "R6 first then second ack";
        steps(2);
        done_pulse(8'h11);
        phase = "R7 lock across pair";
        steps(3);
        phase = "R8 vector capture";
        done_pulse(8'hA5);
        steps(1);
        intr_pin = 1'b0;
        steps(4);

        phase = "R5 enable gating";
        irq_enable = 1'b0; intr_pin = 1'b1;
        steps(6);
        irq_enable = 1'b1;
        steps(2);
        phase = "R9 drop in first cycle";
        intr_pin = 1'b0;
        steps(3);
        done_pulse(8'hEE);
        steps(3);

        phase = "R9 drop in second cycle";
        intr_pin = 1'b1;
        steps(4);
        done_pulse(8'h22);
        intr_pin = 1'b0;
        steps(3);
        done_pulse(8'h77);
        steps(3);

        phase = "R3 long low run";
        nmi_pin = 1'b1;
        steps(4);
        phase = "R4 ack clears";
        nmi_ack = 1'b1; steps(1); nmi_ack = 1'b0;
        steps(2);
        nmi_ack = 1'b1; steps(1); nmi_ack = 1'b0;
        steps(1);

        phase = "R2 short low runs";
        nmi_pin = 1'b0; steps(2); nmi_pin = 1'b1; steps(4);
        nmi_pin = 1'b0; steps(3); nmi_pin = 1'b1; steps(4);
        phase = "R2 minimum low run";
        nmi_pin = 1'b0; steps(4); nmi_pin = 1'b1; steps(4);

        phase = "R10 nmi priority";
        intr_pin = 1'b1; irq_enable = 1'b1;
        steps(6);
        nmi_ack = 1'b1; steps(1); nmi_ack = 1'b0;
        steps(3);
        done_pulse(8'h5A);
        steps(2);
        done_pulse(8'h3C);
        intr_pin = 1'b0;
        steps(4);

        phase = "R4 edge and ack together";
        nmi_pin = 1'b0; steps(6);
        nmi_ack = 1'b1; nmi_pin = 1'b1;
        steps(5);
        nmi_ack = 1'b0;
        steps(3);
        nmi_pin = 1'b0; steps(20); nmi_pin = 1'b1;
        phase = "R3 saturated run";
        steps(5);
        nmi_ack = 1'b1; steps(1); nmi_ack = 1'b0;
        steps(3);

        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end
endmodule